// File: doc/BRIEF.md
# Program ROM Window Mapper

This block sits between a CPU and a program ROM and maps the upper half of the CPU address space ($8000–$FFFF) onto the ROM in 8 KB pages. CPU address bits 14:13 pick one of four windows. The three lower windows are switchable. Each takes its page number from a register. The top window ($E000–$FFFF) always reaches the last page of the ROM, so reset and interrupt vectors are always present there. The usual split puts program code in the first window and tables or music data in the second. The third window holds the sample that is playing at the moment.

Software changes pages by writing into the same address range. CPU address bits 1:0 pick the register, bit 2 picks the lower or upper nibble of the page, and data bits 3:0 carry the new nibble. A parameter sets the page width. With 4 bits the block reaches 128 KB of ROM; with 8 bits it reaches 2 MB, and the upper nibble is stored in a second plane of the register file. The block drives the ROM address lines above bit 12 and an active-low ROM chip enable. The CPU drives address bits 12:0 straight to the ROM.

Top module: `prg_window_mapper`

## Requirements
- R1: After a synchronous reset all three switchable pages are 0, so windows 0, 1 and 2 give `rom_addr_hi` = 0.
- R2: When `cpu_addr[14:13]` = 3, `rom_addr_hi` is all ones, whatever the page registers hold.
- R3: A write with `cpu_addr[2]` = 0 and `cpu_addr[1:0]` = n (n in 0..2) loads `cpu_data[3:0]` into the low nibble of page n. The new value is visible from the cycle after the write clock edge.
- R4: When `cpu_addr[14:13]` = n (n in 0..2), `rom_addr_hi` shows page n. The change is combinational and takes effect in the same cycle as the address, including at the last address of a window ($1FFF, $5FFF).
- R5: A write with `cpu_addr[1:0]` = 3 changes no page.
- R6: With PAGE_BITS = 8, a write with `cpu_addr[2]` = 1 loads `cpu_data[3:0]` into the high nibble of page n and leaves the low nibble as it was. With PAGE_BITS = 4, such a write changes nothing.
- R7: `rom_ce_n` is low exactly when `rom_sel_n` is low and `cpu_rw` is high (read).
- R8: A page register is written only in a cycle where `rom_sel_n` is low and `cpu_rw` is low. With `rom_sel_n` high, a write cycle leaves every page unchanged.
- R9: Data bits 7:4 of a write have no effect on the stored page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 15 | CPU address bits 14:0 |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_sel_n | input | 1 | Active-low strobe: access to $8000–$FFFF |
| rom_addr_hi | output | PAGE_BITS | ROM address bits above bit 12 |
| rom_ce_n | output | 1 | Active-low ROM chip enable |

## Verification
The hardest case to reach is building a full 8-bit page from two separate nibble writes, then showing that neither write disturbed the other half or a different window. The stimulus writes the high and low nibbles of different pages in a mixed order. It includes writes to register 3 and writes with junk in the upper data bits. After each group of writes it reads all four windows. A 4-bit instance runs on the same inputs, so the same writes must leave its high-nibble writes unused.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int NIB_W     = 4;
    localparam int NUM_WIN   = 3;
    localparam int IDX_W     = 2;
    localparam int WR_ADDR_W = 3;

    // Window codes taken from cpu_addr[14:13]
    typedef enum logic [IDX_W-1:0] {
        WIN_CODE   = 2'd0,
        WIN_DATA   = 2'd1,
        WIN_SAMPLE = 2'd2,
        WIN_FIXED  = 2'd3
    } win_e;

    // One decoded nibble write request
    typedef struct packed {
        logic             en;
        logic             upper;
        logic [IDX_W-1:0] slot;
        logic [NIB_W-1:0] nib;
    } nib_wr_t;

    function automatic nib_wr_t decode_write(
        input logic                 sel_n,
        input logic                 rw,
        input logic [WR_ADDR_W-1:0] a,
        input logic [7:0]           d
    );
        nib_wr_t r;
        r.slot  = a[IDX_W-1:0];
        r.upper = a[IDX_W];
        r.nib   = d[NIB_W-1:0];
        r.en    = !sel_n && !rw && (a[IDX_W-1:0] != 2'(WIN_FIXED));
        return r;
    endfunction

endpackage

// File: rtl/prg_page_file.sv
module prg_page_file
    import prg_map_pkg::*;
#(
    parameter int PAGE_BITS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  nib_wr_t                        wr,
    output logic [NUM_WIN*PAGE_BITS-1:0]   pages
);
    localparam int PLANES = PAGE_BITS / NIB_W;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [NIB_W-1:0] nib_q [NUM_WIN];
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            always_ff @(posedge clk) begin
                if (rst) begin
                    nib_q[w] <= '0;
                end else if (wr.en && wr.slot == IDX_W'(w) && wr.upper == 1'(p)) begin
                    nib_q[w] <= wr.nib;
                end
            end
            assign pages[w*PAGE_BITS + p*NIB_W +: NIB_W] = nib_q[w];
        end
    end
endmodule

// File: rtl/prg_window_sel.sv
module prg_window_sel
    import prg_map_pkg::*;
#(
    parameter int PAGE_BITS = 8
) (
    input  logic [NUM_WIN*PAGE_BITS-1:0] pages,
    input  win_e                         win,
    input  logic                         sel_n,
    input  logic                         rw,
    output logic [PAGE_BITS-1:0]         page,
    output logic                         ce_n
);
    always_comb begin
        unique case (win)
            WIN_CODE:   page = pages[0*PAGE_BITS +: PAGE_BITS];
            WIN_DATA:   page = pages[1*PAGE_BITS +: PAGE_BITS];
            WIN_SAMPLE: page = pages[2*PAGE_BITS +: PAGE_BITS];
            default:    page = '1;
        endcase
    end

    assign ce_n = !(!sel_n && rw);
endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
    import prg_map_pkg::*;
#(
    parameter int PAGE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [14:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_rw,
    input  logic                 rom_sel_n,
    output logic [PAGE_BITS-1:0] rom_addr_hi,
    output logic                 rom_ce_n
);
    nib_wr_t                      wr_req;
    logic [NUM_WIN*PAGE_BITS-1:0] page_vec;
    win_e                         win_code;

    assign wr_req   = decode_write(rom_sel_n, cpu_rw, cpu_addr[WR_ADDR_W-1:0], cpu_data);
    assign win_code = win_e'(cpu_addr[14:13]);

    prg_page_file #(.PAGE_BITS(PAGE_BITS)) u_file (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_req),
        .pages (page_vec)
    );

    prg_window_sel #(.PAGE_BITS(PAGE_BITS)) u_sel (
        .pages (page_vec),
        .win   (win_code),
        .sel_n (rom_sel_n),
        .rw    (cpu_rw),
        .page  (rom_addr_hi),
        .ce_n  (rom_ce_n)
    );
endmodule

// File: rtl/prg_window_mapper_chk.sv
module prg_window_mapper_chk #(
    parameter int PAGE_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [14:0]          cpu_addr,
    input logic                 cpu_rw,
    input logic                 rom_sel_n,
    input logic [PAGE_BITS-1:0] rom_addr_hi,
    input logic                 rom_ce_n
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_fixed_top_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[14:13] == 2'd3) |-> (rom_addr_hi == {PAGE_BITS{1'b1}}));

    p_reset_zero_r1: assert property (@(posedge clk)
        ($past(rst) && !rst && cpu_addr[14:13] != 2'd3) |-> (rom_addr_hi == '0));

    p_ce_only_read_r7: assert property (@(posedge clk) disable iff (rst)
        !rom_ce_n |-> (!rom_sel_n && cpu_rw));

    p_ce_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        (!rom_sel_n && cpu_rw) |-> !rom_ce_n);

    // R8: no write strobe in the previous cycle means the selected page holds
    p_hold_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(rom_sel_n) || $past(cpu_rw)) && $stable(cpu_addr[14:13]))
        |-> $stable(rom_addr_hi));
endmodule

bind prg_window_mapper prg_window_mapper_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .cpu_rw      (cpu_rw),
    .rom_sel_n   (rom_sel_n),
    .rom_addr_hi (rom_addr_hi),
    .rom_ce_n    (rom_ce_n)
);

// File: tb/prg_window_mapper_bench.sv
module prg_window_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        rom_sel_n = 1'b1;
    logic [7:0]  hi_w;
    logic [3:0]  hi_n;
    logic        ce_w, ce_n4;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    prg_window_mapper #(.PAGE_BITS(8)) u_prg_window_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n), .rom_addr_hi(hi_w), .rom_ce_n(ce_w));

    prg_window_mapper #(.PAGE_BITS(4)) u_narrow (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n), .rom_addr_hi(hi_n), .rom_ce_n(ce_n4));

    typedef struct packed {
        logic        is_wr;
        logic [14:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp_w;
        logic [3:0]  exp_n;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 15'h0000, 8'h25, 8'h00, 4'h0, 4'd3},  // R3 page0 low = 5
        '{1'b1, 15'h0004, 8'h0A, 8'h00, 4'h0, 4'd6},  // R6 page0 high = A
        '{1'b1, 15'h0001, 8'h03, 8'h00, 4'h0, 4'd3},  // R3 page1 low = 3
        '{1'b1, 15'h0006, 8'h0C, 8'h00, 4'h0, 4'd6},  // R6 page2 high = C
        '{1'b1, 15'h0002, 8'h07, 8'h00, 4'h0, 4'd3},  // R3 page2 low = 7
        '{1'b0, 15'h0000, 8'h00, 8'hA5, 4'h5, 4'd4},  // R4 window 0
        '{1'b0, 15'h2000, 8'h00, 8'h03, 4'h3, 4'd4},  // R4 window 1
        '{1'b0, 15'h4000, 8'h00, 8'hC7, 4'h7, 4'd4},  // R4 window 2
        '{1'b0, 15'h6000, 8'h00, 8'hFF, 4'hF, 4'd2},  // R2 fixed window
        '{1'b0, 15'h1FFF, 8'h00, 8'hA5, 4'h5, 4'd4},  // R4 window 0 last byte
        '{1'b0, 15'h5FFF, 8'h00, 8'hC7, 4'h7, 4'd4},  // R4 window 2 last byte
        '{1'b0, 15'h7FFF, 8'h00, 8'hFF, 4'hF, 4'd2},  // R2 last address
        '{1'b1, 15'h0003, 8'h0E, 8'h00, 4'h0, 4'd5},  // R5 index 3 low
        '{1'b1, 15'h0007, 8'h0E, 8'h00, 4'h0, 4'd5},  // R5 index 3 high
        '{1'b0, 15'h0000, 8'h00, 8'hA5, 4'h5, 4'd5},
        '{1'b0, 15'h2000, 8'h00, 8'h03, 4'h3, 4'd5},
        '{1'b0, 15'h4000, 8'h00, 8'hC7, 4'h7, 4'd5},
        '{1'b1, 15'h0001, 8'hF9, 8'h00, 4'h0, 4'd9},  // R9 junk upper data
        '{1'b0, 15'h2000, 8'h00, 8'h09, 4'h9, 4'd9},
        '{1'b1, 15'h0000, 8'h02, 8'h00, 4'h0, 4'd6},  // R6 low only, high stays A
        '{1'b0, 15'h0000, 8'h00, 8'hA2, 4'h2, 4'd6},
        '{1'b0, 15'h6000, 8'h00, 8'hFF, 4'hF, 4'd2}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; rom_sel_n = 1'b0;
        @(negedge clk);
        rom_sel_n = 1'b1; cpu_rw = 1'b1;
    endtask

    task automatic set_read(input logic [14:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b1; rom_sel_n = 1'b0;
        #5;
    endtask

    task automatic check_reset_pages(input string tag);
        set_read(15'h0000); check({tag, " win0"}, hi_w, 8'h00);
        set_read(15'h2000); check({tag, " win1"}, hi_w, 8'h00);
        set_read(15'h4000); check({tag, " win2"}, hi_w, 8'h00);
        check({tag, " narrow win2"}, {4'h0, hi_n}, 8'h00);
        set_read(15'h6000); check("R2 after reset", hi_w, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        check_reset_pages("R1 reset");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                set_read(VECS[i].addr);
                check($sformatf("R%0d vec%0d wide", VECS[i].req, i), hi_w, VECS[i].exp_w);
                check($sformatf("R%0d vec%0d narrow", VECS[i].req, i), {4'h0, hi_n}, {4'h0, VECS[i].exp_n});
            end
        end

        // R7 chip enable decode
        set_read(15'h0000);
        check("R7 read enables", {7'h0, ce_w}, 8'h00);
        @(negedge clk); rom_sel_n = 1'b1; #5;
        check("R7 no select", {7'h0, ce_w}, 8'h01);
        @(negedge clk); cpu_addr = 15'h0003; cpu_rw = 1'b0; rom_sel_n = 1'b0; #5;
        check("R7 write cycle", {7'h0, ce_w}, 8'h01);
        @(negedge clk); cpu_rw = 1'b1; rom_sel_n = 1'b1;

        // R8 write strobe without select
        @(negedge clk);
        cpu_addr = 15'h0000; cpu_data = 8'h0F; cpu_rw = 1'b0; rom_sel_n = 1'b1;
        @(negedge clk); cpu_rw = 1'b1;
        set_read(15'h0000);
        check("R8 unselected write", hi_w, 8'hA2);
        check("R8 unselected write narrow", {4'h0, hi_n}, 8'h02);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_reset_pages("R1 rerun");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule